// File: doc/BRIEF.md
# Serial Receive Port with Synchronized Enable

This block receives a serial bit stream on a clock supplied by the sending device and assembles it into parallel words. A control-side enable bit, which has no fixed phase relation to the serial clock, is passed through a two-stage synchronizer before the port reacts to anything on the line. Only on the third serial clock edge after the enable rises does the port start searching for a frame sync. Any frame sync seen before that edge is ignored.

Two framings are offered. In the coincident framing, the frame sync is sampled on the same edge as the first data bit. In the leading framing, the frame sync comes one edge before the first data bit. The frame sync can be made active high or active low. In framed mode every word needs its own frame sync. In continuous mode only the first word is framed, and words then follow back to back.

Frame sync detection is level based. A frame sync held from the first clock edge therefore starts reception on the first active edge, and the leading bits are lost: two with coincident framing, three with leading framing. Holding the frame sync inactive for at least two edges after enabling, and then asserting it, loses nothing. Each finished word is presented with a one-cycle valid strobe in the serial clock domain.

Top module: `serial_rx_port`

## Requirements
- R1: After `en_req` is set before serial clock edge 1, the frame sync is first evaluated on edge 3. A frame sync present on edges 1 and 2 only starts no word.
- R2: With `frame_lead`=0 (coincident framing), the data bit sampled on the same edge as an accepted frame sync is the first bit of the word.
- R3: With `frame_lead`=1 (leading framing), the first bit of the word is sampled on the edge after the accepted frame sync.
- R4: With `fs_low`=0 the frame sync is active when `fs_in` is 1. With `fs_low`=1 it is active when `fs_in` is 0.
- R5: With `cont_mode`=1 only the first word needs a frame sync, and later words follow with no gap. If the frame sync is held active from edge 1, the first word begins with the bit of edge 3 (coincident framing) or edge 4 (leading framing).
- R6: With `cont_mode`=0 each word needs its own frame sync. A frame sync sampled while a word is being shifted in is ignored. After a word ends, no new word starts until another frame sync arrives.
- R7: Bits arrive MSB first. `rx_word` holds the word in its low L bits and zeros above them. L is `word_len` limited to the range 3..16: values below 3 act as 3 and values above 16 act as 16.
- R8: `rx_valid` is high for exactly one cycle, after the edge that samples the last bit of a word. `rx_word` carries that word in the same cycle.
- R9: Clearing `en_req` returns the port to idle at once. The partial word is discarded, no `rx_valid` follows, and `rx_word` reads zero.
- R10: While `rst_n` is low, `rx_valid` is 0 and `rx_word` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock from the sender; inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_req | input | 1 | Control-side enable, asynchronous to sclk |
| frame_lead | input | 1 | 1: frame sync precedes the first bit by one edge; 0: frame sync coincides with the first bit |
| cont_mode | input | 1 | 1: only the first word is framed |
| fs_low | input | 1 | 1: frame sync is active low |
| word_len | input | 5 | Requested word length in bits, limited to 3..16 |
| fs_in | input | 1 | Frame sync line |
| sdata | input | 1 | Serial data line |
| rx_word | output | 16 | Last received word, right aligned |
| rx_valid | output | 1 | One-cycle strobe marking a new word |

## Verification
Every word length is swept under both framings and both polarities, with several frame-sync patterns:
- A clean pulse on edge 3 pins down the exact first active edge and the bit alignment of each framing.
- A frame sync held from edge 1 in continuous mode must show exactly two or three lost leading bits, which separates the enable delay from the framing offset.
- A second pulse placed inside a word, and pulses confined to edges 1 and 2, show that the sync is gated by the shifting state and by the enable delay.
- Dropping the enable partway through a word tells an immediate abort apart from one that lets the word finish.
- Out-of-range lengths check the limiting of `word_len`.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic {
    RX_HUNT  = 1'b0,
    RX_SHIFT = 1'b1
  } rx_state_t;

  // Limit a requested word length to the supported range.
  function automatic int unsigned clamp_len(input int unsigned req,
                                            input int unsigned lo,
                                            input int unsigned hi);
    if (req < lo) return lo;
    if (req > hi) return hi;
    return req;
  endfunction

  // Logical frame-sync level after polarity selection.
  function automatic logic fs_level(input logic pin, input logic active_low);
    return pin ^ active_low;
  endfunction

endpackage

// File: rtl/srx_en_sync.sv
module srx_en_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic sclk,
  input  logic rst_n,
  input  logic en_req,
  output logic port_active
);
  logic clr_n;
  logic [STAGES-1:0] chain;

  assign clr_n = rst_n & en_req;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge sclk or negedge clr_n) begin
          if (!clr_n) chain[0] <= 1'b0;
          else        chain[0] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge sclk or negedge clr_n) begin
          if (!clr_n) chain[s] <= 1'b0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign port_active = chain[STAGES-1];
endmodule

// File: rtl/srx_fs_detect.sv
module srx_fs_detect
  import srx_pkg::*;
(
  input  logic port_active,
  input  logic fs_in,
  input  logic fs_low,
  output logic fs_hit
);
  assign fs_hit = port_active & fs_level(fs_in, fs_low);
endmodule

// File: rtl/srx_shifter.sv
module srx_shifter
  import srx_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned LW = 5
) (
  input  logic          sclk,
  input  logic          clr_n,
  input  logic          port_active,
  input  logic          fs_hit,
  input  logic          sdata,
  input  logic          frame_lead,
  input  logic          cont_mode,
  input  logic [LW-1:0] word_len,
  output logic [DW-1:0] rx_word,
  output logic          rx_valid,
  output logic          word_done
);
  localparam int unsigned MIN_LEN = 3;

  rx_state_t     state;
  logic [LW-1:0] cnt;
  logic [DW-1:0] sh;
  logic [LW-1:0] eff_len;
  logic [LW-1:0] cnt_next;
  logic [DW-1:0] sh_next;
  logic          start;

  assign eff_len   = LW'(clamp_len(int'(word_len), MIN_LEN, DW));
  assign cnt_next  = cnt + LW'(1);
  assign sh_next   = {sh[DW-2:0], sdata};
  assign start     = port_active && (state == RX_HUNT) && fs_hit;
  assign word_done = port_active && (state == RX_SHIFT) && (cnt_next == eff_len);

  always_ff @(posedge sclk or negedge clr_n) begin
    if (!clr_n) begin
      state    <= RX_HUNT;
      cnt      <= '0;
      sh       <= '0;
      rx_word  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= word_done;
      if (!port_active) begin
        state <= RX_HUNT;
        cnt   <= '0;
        sh    <= '0;
      end else if (start) begin
        state <= RX_SHIFT;
        if (frame_lead) begin
          cnt <= '0;
          sh  <= '0;
        end else begin
          cnt <= LW'(1);
          sh  <= DW'(sdata);
        end
      end else if (state == RX_SHIFT) begin
        if (word_done) begin
          rx_word <= sh_next;
          cnt     <= '0;
          sh      <= '0;
          state   <= cont_mode ? RX_SHIFT : RX_HUNT;
        end else begin
          cnt <= cnt_next;
          sh  <= sh_next;
        end
      end
    end
  end
endmodule

// File: rtl/serial_rx_port.sv
module serial_rx_port #(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned LEN_W       = $clog2(DATA_W + 1)
) (
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              en_req,
  input  logic              frame_lead,
  input  logic              cont_mode,
  input  logic              fs_low,
  input  logic [LEN_W-1:0]  word_len,
  input  logic              fs_in,
  input  logic              sdata,
  output logic [DATA_W-1:0] rx_word,
  output logic              rx_valid
);
  logic clr_n;
  logic port_active;
  logic fs_hit;
  logic word_done;

  assign clr_n = rst_n & en_req;

  srx_en_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .sclk        (sclk),
    .rst_n       (rst_n),
    .en_req      (en_req),
    .port_active (port_active)
  );

  srx_fs_detect fs_i (
    .port_active (port_active),
    .fs_in       (fs_in),
    .fs_low      (fs_low),
    .fs_hit      (fs_hit)
  );

  srx_shifter #(.DW(DATA_W), .LW(LEN_W)) shift_i (
    .sclk        (sclk),
    .clr_n       (clr_n),
    .port_active (port_active),
    .fs_hit      (fs_hit),
    .sdata       (sdata),
    .frame_lead  (frame_lead),
    .cont_mode   (cont_mode),
    .word_len    (word_len),
    .rx_word     (rx_word),
    .rx_valid    (rx_valid),
    .word_done   (word_done)
  );
endmodule

// File: rtl/srx_chk.sv
module srx_chk
  import srx_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned LW = 5
) (
  input logic          sclk,
  input logic          rst_n,
  input logic          en_req,
  input logic          port_active,
  input logic          word_done,
  input logic          rx_valid,
  input logic [DW-1:0] rx_word,
  input logic [LW-1:0] word_len
);
  // R1
  en_delay_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    $rose(port_active) |-> ($past(en_req) && $past(en_req, 2)));

  // R9
  en_gate_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    !$past(en_req) |-> !port_active);

  // R9
  idle_quiet_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    !port_active |=> !rx_valid);

  // R8
  valid_pulse_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R8
  done_to_valid_chk: assert property (@(posedge sclk) disable iff (!rst_n || !en_req)
    word_done |=> rx_valid);

  // R7
  word_width_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    rx_valid |-> ((rx_word >> clamp_len(int'(word_len), 3, DW)) == '0));
endmodule

bind serial_rx_port srx_chk #(.DW(DATA_W), .LW(LEN_W)) chk_i (
  .sclk        (sclk),
  .rst_n       (rst_n),
  .en_req      (en_req),
  .port_active (port_active),
  .word_done   (word_done),
  .rx_valid    (rx_valid),
  .rx_word     (rx_word),
  .word_len    (word_len)
);

// File: tb/serial_rx_port_tb.sv
`timescale 1ns/1ps
module serial_rx_port_tb_top;
  logic        sclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_req = 1'b0;
  logic        frame_lead = 1'b0;
  logic        cont_mode = 1'b0;
  logic        fs_low = 1'b0;
  logic [4:0]  word_len = 5'd8;
  logic        fs_in = 1'b0;
  logic        sdata = 1'b0;
  logic [15:0] rx_word;
  logic        rx_valid;

  int total = 0;
  int fails = 0;
  bit done = 0;

  always #5 sclk = ~sclk;

  serial_rx_port dut_i (
    .sclk(sclk), .rst_n(rst_n), .en_req(en_req), .frame_lead(frame_lead),
    .cont_mode(cont_mode), .fs_low(fs_low), .word_len(word_len),
    .fs_in(fs_in), .sdata(sdata), .rx_word(rx_word), .rx_valid(rx_valid)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic dbit(input int e, input int seed);
    logic [31:0] h;
    h = (32'(e) + 32'(seed)) * 32'h9E3779B1;
    return ^h[22:6];
  endfunction

  // mode 0: clean pulse on edge 3; 1: held from edge 1; 2: pulse at 5 plus
  // intruder at 7; 3: pulses on edges 1,2 only; 4: pulse at 3, enable dropped after edge 4
  function automatic bit fs_pat(input int mode, input int e);
    case (mode)
      0: return e == 3;
      1: return 1'b1;
      2: return (e == 5) || (e == 7);
      3: return (e == 1) || (e == 2);
      default: return e == 3;
    endcase
  endfunction

  task automatic run(input int lreq, input bit lead, input bit cont,
                     input bit low, input int mode, input int seed, input string tag);
    int L;
    int d;
    int ne;
    L = (lreq < 3) ? 3 : ((lreq > 16) ? 16 : lreq);
    d = ((mode == 2) ? 5 : 3) + (lead ? 1 : 0);
    ne = (mode >= 3) ? 20 : d + 3 * L + 3;
    @(negedge sclk);
    word_len = 5'(lreq); frame_lead = lead; cont_mode = cont; fs_low = low;
    en_req = 1'b1;
    for (int e = 1; e <= ne; e++) begin
      fs_in = fs_pat(mode, e) ^ low;
      sdata = dbit(e, seed);
      @(posedge sclk);
      @(negedge sclk);
      begin
        int k;
        bit ev;
        logic [15:0] w;
        k = e - d + 1;
        ev = (mode < 3) && (k > 0) && (k % L == 0) && (cont || k == L);
        chk(rx_valid == ev, $sformatf("%s/R8 L=%0d e=%0d", tag, L, e), 32'(rx_valid), 32'(ev));
        if (ev) begin
          w = '0;
          for (int i = 0; i < L; i++) w = (w << 1) | 16'(dbit(e - L + 1 + i, seed));
          chk(rx_word == w, $sformatf("%s/R7 L=%0d e=%0d", tag, L, e), 32'(rx_word), 32'(w));
        end
      end
      if (mode == 4 && e == 4) en_req = 1'b0;
    end
    en_req = 1'b0;
    fs_in = low;
    repeat (2) @(negedge sclk);
    chk(rx_valid == 1'b0 && rx_word == 16'h0, {tag, "/R9 idle after disable"},
        {15'h0, rx_valid, rx_word}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge sclk);
    // R10: reset state
    chk(rx_valid == 1'b0, "R10 valid in reset", 32'(rx_valid), 32'h0);
    chk(rx_word == 16'h0, "R10 word in reset", 32'(rx_word), 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge sclk);
    for (int L = 3; L <= 16; L++) begin
      for (int lead = 0; lead < 2; lead++) begin
        for (int low = 0; low < 2; low++) begin
          string ft;
          ft = (low != 0) ? "R4" : ((lead != 0) ? "R3" : "R2");
          run(L, lead[0], 1'b0, low[0], 0, L * 7 + lead, {ft, "/R1 framed"});
          run(L, lead[0], 1'b1, low[0], 0, L * 5 + 3, {ft, "/R5 continuous"});
          run(L, lead[0], 1'b1, low[0], 1, L * 3 + 11, "R5 held sync");
          run(L, lead[0], 1'b0, low[0], 2, L + 19, "R6 intruder sync");
          run(L, lead[0], 1'b0, low[0], 3, L + 23, "R1 early sync");
          run(L, lead[0], 1'b0, low[0], 4, L + 29, "R9 abort");
        end
      end
    end
    // R7: length limiting
    run(0, 1'b0, 1'b1, 1'b0, 0, 41, "R7 len0");
    run(2, 1'b1, 1'b1, 1'b0, 0, 43, "R7 len2");
    run(17, 1'b0, 1'b1, 1'b1, 0, 47, "R7 len17");
    run(31, 1'b1, 1'b0, 1'b0, 0, 53, "R7 len31");
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule